// File: doc/BRIEF.md
# Instruction Count Step Trigger

This block is a debug trigger that counts instruction retirements and taken traps, and fires when its count runs out. Each event carries the privilege mode it happened in. Three enable bits pick which modes count. When the count steps from one to zero, the block raises a one-cycle fire pulse that carries the configured action code, and it sets a sticky hit flag. Software sees the hit flag and can rewrite it.

Configuration comes through one write strobe. The strobe loads the count, the three mode enables, the hit flag and the action code together, and the stored values are always readable. The block has a build option meant for single stepping. With this option the count is held at one, and a counted event clears all three mode enables. Turning that action into debug entry or an exception belongs to other logic.

Top module: `icnt_step_trig`

## Requirements
- R1: Each counted event lowers the count by exactly one. A retire strobe and a trap strobe in the same cycle make one event.
- R2: When a counted event takes the count from 1 to 0, `fire_o` is high for exactly the one cycle after that event, and `fire_action_o` carries the stored action during it. At all other times `fire_action_o` is zero.
- R3: An event counts only when the enable for its mode is set. The mode codes are 0 user, 1 supervisor and 3 machine. Code 2 never counts.
- R4: With `STEP_ONLY`=1, the count always reads 1 and writes to it are ignored. A counted event fires and clears all three mode enables.
- R5: After reset the count is 1, the enables, action and hit are 0, and no fire is pending.
- R6: A fire sets the hit flag. A configuration write loads the hit flag with the written value.
- R7: While the count is 0 and no write occurs, the count stays 0 and nothing fires.
- R8: A configuration write in the same cycle as an event wins. The written values are stored, the event is dropped and nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction completed this cycle |
| trap_i | input | 1 | A trap was taken this cycle |
| priv_i | input | 2 | Privilege mode of this cycle's event |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_count_i | input | CNT_W | Count value to write |
| cfg_en_m_i | input | 1 | Machine-mode enable to write |
| cfg_en_s_i | input | 1 | Supervisor-mode enable to write |
| cfg_en_u_i | input | 1 | User-mode enable to write |
| cfg_hit_i | input | 1 | Hit flag value to write |
| cfg_action_i | input | ACT_W | Action code to write |
| fire_o | output | 1 | One-cycle fire pulse |
| fire_action_o | output | ACT_W | Action code while firing, else zero |
| hit_o | output | 1 | Hit flag |
| count_o | output | CNT_W | Current count |
| en_m_o | output | 1 | Machine-mode enable |
| en_s_o | output | 1 | Supervisor-mode enable |
| en_u_o | output | 1 | User-mode enable |
| action_o | output | ACT_W | Stored action code |

## Verification
The bench builds two copies with the default 14-bit count and 4-bit action and drives both from the same stimulus. The copy with `STEP_ONLY`=0 reaches the decrement path, the 1-to-0 fire, the hold at zero and the priority of writes over events. The copy with `STEP_ONLY`=1 reaches the variant where the count is fixed at one and the enables are cleared, including a count write that it must ignore.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic m;
        logic s;
        logic u;
    } mode_en_t;

endpackage

// File: rtl/icnt_evt_qual.sv
module icnt_evt_qual
    import icnt_pkg::*;
(
    input  logic     retire_i,
    input  logic     trap_i,
    input  logic [1:0] priv_i,
    input  mode_en_t en_i,
    output logic     evt_o
);
    logic mode_ok;

    always_comb begin
        unique case (priv_e'(priv_i))
            PRIV_MACH:  mode_ok = en_i.m;
            PRIV_SUPER: mode_ok = en_i.s;
            PRIV_USER:  mode_ok = en_i.u;
            default:    mode_ok = 1'b0;
        endcase
    end

    // retire and trap in one cycle form a single event
    assign evt_o = (retire_i | trap_i) & mode_ok;
endmodule

// File: rtl/icnt_cnt_next.sv
module icnt_cnt_next #(
    parameter int unsigned CNT_W     = 14,
    parameter bit          STEP_ONLY = 1'b0
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             evt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fire_o,
    output logic             clr_en_o
);
    localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

    generate
        if (STEP_ONLY) begin : g_step
            // count pinned at one; hitting it disarms via the enables
            always_comb begin
                count_o  = CntOne;
                fire_o   = evt_i;
                clr_en_o = evt_i;
            end
        end else begin : g_dec
            logic nonzero;
            assign nonzero = |count_i;
            always_comb begin
                count_o  = count_i;
                fire_o   = 1'b0;
                clr_en_o = 1'b0;
                if (evt_i && nonzero) begin
                    count_o = count_i - CntOne;
                    fire_o  = (count_i == CntOne);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/icnt_step_trig.sv
module icnt_step_trig
    import icnt_pkg::*;
#(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned ACT_W     = 4,
    parameter bit          STEP_ONLY = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             retire_i,
    input  logic             trap_i,
    input  logic [1:0]       priv_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_count_i,
    input  logic             cfg_en_m_i,
    input  logic             cfg_en_s_i,
    input  logic             cfg_en_u_i,
    input  logic             cfg_hit_i,
    input  logic [ACT_W-1:0] cfg_action_i,
    output logic             fire_o,
    output logic [ACT_W-1:0] fire_action_o,
    output logic             hit_o,
    output logic [CNT_W-1:0] count_o,
    output logic             en_m_o,
    output logic             en_s_o,
    output logic             en_u_o,
    output logic [ACT_W-1:0] action_o
);
    localparam logic [CNT_W-1:0] CntReset = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        mode_en_t         en;
        logic             hit;
        logic [ACT_W-1:0] action;
        logic             fire;
        logic [ACT_W-1:0] fire_act;
    } state_t;

    state_t state_d, state_q;

    logic             evt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_fire;
    logic             cnt_clr_en;

    icnt_evt_qual u_qual (
        .retire_i (retire_i),
        .trap_i   (trap_i),
        .priv_i   (priv_i),
        .en_i     (state_q.en),
        .evt_o    (evt)
    );

    icnt_cnt_next #(
        .CNT_W     (CNT_W),
        .STEP_ONLY (STEP_ONLY)
    ) u_cnt (
        .count_i  (state_q.count),
        .evt_i    (evt),
        .count_o  (cnt_nxt),
        .fire_o   (cnt_fire),
        .clr_en_o (cnt_clr_en)
    );

    always_comb begin
        state_d          = state_q;
        state_d.fire     = 1'b0;
        state_d.fire_act = '0;
        if (cfg_we_i) begin
            state_d.count  = STEP_ONLY ? CntReset : cfg_count_i;
            state_d.en.m   = cfg_en_m_i;
            state_d.en.s   = cfg_en_s_i;
            state_d.en.u   = cfg_en_u_i;
            state_d.hit    = cfg_hit_i;
            state_d.action = cfg_action_i;
        end else begin
            state_d.count = cnt_nxt;
            if (cnt_clr_en) begin
                state_d.en = '0;
            end
            if (cnt_fire) begin
                state_d.hit      = 1'b1;
                state_d.fire     = 1'b1;
                state_d.fire_act = state_q.action;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q          <= '0;
            state_q.count    <= CntReset;
        end else begin
            state_q <= state_d;
        end
    end

    assign fire_o        = state_q.fire;
    assign fire_action_o = state_q.fire_act;
    assign hit_o         = state_q.hit;
    assign count_o       = state_q.count;
    assign en_m_o        = state_q.en.m;
    assign en_s_o        = state_q.en.s;
    assign en_u_o        = state_q.en.u;
    assign action_o      = state_q.action;
endmodule

// File: rtl/icnt_step_trig_chk.sv
module icnt_step_trig_chk #(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned ACT_W     = 4,
    parameter bit          STEP_ONLY = 1'b0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             retire_i,
    input logic             trap_i,
    input logic [1:0]       priv_i,
    input logic             cfg_we_i,
    input logic [CNT_W-1:0] cfg_count_i,
    input logic             cfg_en_m_i,
    input logic             cfg_en_s_i,
    input logic             cfg_en_u_i,
    input logic             cfg_hit_i,
    input logic [ACT_W-1:0] cfg_action_i,
    input logic             fire_o,
    input logic [ACT_W-1:0] fire_action_o,
    input logic             hit_o,
    input logic [CNT_W-1:0] count_o,
    input logic             en_m_o,
    input logic             en_s_o,
    input logic             en_u_o,
    input logic [ACT_W-1:0] action_o
);
    logic counted;
    assign counted = (retire_i | trap_i) &&
                     ((priv_i == 2'd3 && en_m_o) ||
                      (priv_i == 2'd1 && en_s_o) ||
                      (priv_i == 2'd0 && en_u_o));

    p_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |=> !fire_o);

    p_quiet_action_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fire_o |-> fire_action_o == '0);

    p_fire_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> hit_o);

    p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!counted && !cfg_we_i) |=> ($stable(count_o) && !fire_o));

    generate
        if (STEP_ONLY) begin : g_step_chk
            p_step_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (counted && !cfg_we_i) |=>
                    (fire_o && !en_m_o && !en_s_o && !en_u_o && count_o == CNT_W'(1)));
        end else begin : g_dec_chk
            p_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (counted && !cfg_we_i && count_o > CNT_W'(1)) |=>
                    (count_o == $past(count_o) - CNT_W'(1) && !fire_o));

            p_fire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (counted && !cfg_we_i && count_o == CNT_W'(1)) |=>
                    (fire_o && count_o == '0 && fire_action_o == $past(action_o)));

            p_zero_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (count_o == '0 && !cfg_we_i) |=> (count_o == '0 && !fire_o));

            p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                cfg_we_i |=> (!fire_o && count_o == $past(cfg_count_i)));
        end
    endgenerate
endmodule

bind icnt_step_trig icnt_step_trig_chk #(
    .CNT_W     (CNT_W),
    .ACT_W     (ACT_W),
    .STEP_ONLY (STEP_ONLY)
) u_chk (.*);

// File: tb/icnt_step_trig_tb.sv
module icnt_step_trig_tb_top;
    localparam int CNT_W = 14;
    localparam int ACT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             retire = 1'b0, trap = 1'b0;
    logic [1:0]       priv = 2'd0;
    logic             we = 1'b0;
    logic [CNT_W-1:0] w_cnt = '0;
    logic             w_m = 1'b0, w_s = 1'b0, w_u = 1'b0, w_hit = 1'b0;
    logic [ACT_W-1:0] w_act = '0;

    logic             fire_a, hit_a, em_a, es_a, eu_a;
    logic [ACT_W-1:0] fact_a, act_a;
    logic [CNT_W-1:0] cnt_a;
    logic             fire_b, hit_b, em_b, es_b, eu_b;
    logic [ACT_W-1:0] fact_b, act_b;
    logic [CNT_W-1:0] cnt_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    icnt_step_trig #(.CNT_W(CNT_W), .ACT_W(ACT_W), .STEP_ONLY(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .trap_i(trap), .priv_i(priv),
        .cfg_we_i(we), .cfg_count_i(w_cnt), .cfg_en_m_i(w_m), .cfg_en_s_i(w_s),
        .cfg_en_u_i(w_u), .cfg_hit_i(w_hit), .cfg_action_i(w_act),
        .fire_o(fire_a), .fire_action_o(fact_a), .hit_o(hit_a), .count_o(cnt_a),
        .en_m_o(em_a), .en_s_o(es_a), .en_u_o(eu_a), .action_o(act_a));

    icnt_step_trig #(.CNT_W(CNT_W), .ACT_W(ACT_W), .STEP_ONLY(1'b1)) dut_step_i (
        .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .trap_i(trap), .priv_i(priv),
        .cfg_we_i(we), .cfg_count_i(w_cnt), .cfg_en_m_i(w_m), .cfg_en_s_i(w_s),
        .cfg_en_u_i(w_u), .cfg_hit_i(w_hit), .cfg_action_i(w_act),
        .fire_o(fire_b), .fire_action_o(fact_b), .hit_o(hit_b), .count_o(cnt_b),
        .en_m_o(em_b), .en_s_o(es_b), .en_u_o(eu_b), .action_o(act_b));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one cycle from a negedge; outputs are settled at the following negedge
    task automatic cyc(input logic r, input logic t, input logic [1:0] p, input logic w,
                       input int c, input logic m, input logic s, input logic u,
                       input logic h, input int a);
        retire = r; trap = t; priv = p; we = w;
        w_cnt = CNT_W'(c); w_m = m; w_s = s; w_u = u; w_hit = h; w_act = ACT_W'(a);
        @(negedge clk);
        retire = 1'b0; trap = 1'b0; we = 1'b0;
    endtask

    task automatic evt(input logic r, input logic t, input logic [1:0] p);
        cyc(r, t, p, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic wr(input int c, input logic m, input logic s, input logic u,
                      input logic h, input int a);
        cyc(1'b0, 1'b0, 2'd0, 1'b1, c, m, s, u, h, a);
    endtask

    task automatic t_reset;
        chk("R5", "count", int'(cnt_a), 1);
        chk("R5", "enables", int'({em_a, es_a, eu_a}), 0);
        chk("R5", "hit", int'(hit_a), 0);
        chk("R5", "action", int'(act_a), 0);
        chk("R5", "fire", int'(fire_a), 0);
        chk("R5", "step count", int'(cnt_b), 1);
    endtask

    task automatic t_disabled;
        evt(1'b1, 1'b0, 2'd3);
        chk("R3", "count with enables clear", int'(cnt_a), 1);
        chk("R3", "no fire with enables clear", int'(fire_a), 0);
    endtask

    task automatic t_count;
        wr(3, 1'b1, 1'b0, 1'b0, 1'b0, 5);
        chk("R8", "written count", int'(cnt_a), 3);
        evt(1'b1, 1'b0, 2'd3);
        chk("R1", "retire decrement", int'(cnt_a), 2);
        evt(1'b1, 1'b1, 2'd3);
        chk("R1", "retire+trap one step", int'(cnt_a), 1);
        evt(1'b1, 1'b0, 2'd0);
        chk("R3", "user event ignored", int'(cnt_a), 1);
        evt(1'b0, 1'b1, 2'd3);
        chk("R2", "count reached zero", int'(cnt_a), 0);
        chk("R2", "fire pulse", int'(fire_a), 1);
        chk("R2", "fire action", int'(fact_a), 5);
        chk("R6", "hit set by fire", int'(hit_a), 1);
        evt(1'b0, 1'b0, 2'd3);
        chk("R2", "pulse ends", int'(fire_a), 0);
        chk("R2", "action cleared", int'(fact_a), 0);
        evt(1'b1, 1'b0, 2'd3);
        chk("R7", "count holds zero", int'(cnt_a), 0);
        chk("R7", "no refire", int'(fire_a), 0);
    endtask

    task automatic t_hit;
        wr(0, 1'b1, 1'b0, 1'b0, 1'b0, 5);
        chk("R6", "hit cleared by write", int'(hit_a), 0);
        wr(0, 1'b1, 1'b0, 1'b0, 1'b1, 5);
        chk("R6", "hit set by write", int'(hit_a), 1);
    endtask

    task automatic t_priority;
        wr(2, 1'b1, 1'b1, 1'b1, 1'b0, 2);
        cyc(1'b1, 1'b0, 2'd3, 1'b1, 4, 1'b1, 1'b1, 1'b1, 1'b0, 2);
        chk("R8", "write beats event", int'(cnt_a), 4);
        chk("R8", "no fire on write", int'(fire_a), 0);
        wr(1, 1'b1, 1'b0, 1'b0, 1'b0, 2);
        cyc(1'b1, 1'b0, 2'd3, 1'b1, 1, 1'b1, 1'b0, 1'b0, 1'b0, 2);
        chk("R8", "count 1 kept on write", int'(cnt_a), 1);
        chk("R8", "no fire from count 1", int'(fire_a), 0);
    endtask

    task automatic t_priv;
        wr(5, 1'b0, 1'b1, 1'b0, 1'b0, 1);
        evt(1'b1, 1'b0, 2'd2);
        chk("R3", "mode code 2 ignored", int'(cnt_a), 5);
        evt(1'b1, 1'b0, 2'd1);
        chk("R3", "supervisor counted", int'(cnt_a), 4);
        evt(1'b0, 1'b1, 2'd0);
        chk("R3", "user trap ignored", int'(cnt_a), 4);
        evt(1'b0, 1'b1, 2'd3);
        chk("R3", "machine trap ignored", int'(cnt_a), 4);
    endtask

    task automatic t_step;
        wr(7, 1'b0, 1'b0, 1'b1, 1'b0, 3);
        chk("R4", "step count write ignored", int'(cnt_b), 1);
        chk("R4", "step user enable", int'(eu_b), 1);
        evt(1'b1, 1'b0, 2'd0);
        chk("R4", "step fire", int'(fire_b), 1);
        chk("R4", "step action", int'(fact_b), 3);
        chk("R4", "step enables cleared", int'({em_b, es_b, eu_b}), 0);
        chk("R6", "step hit", int'(hit_b), 1);
        chk("R1", "normal copy decrement", int'(cnt_a), 6);
        evt(1'b1, 1'b0, 2'd0);
        chk("R4", "step disarmed", int'(fire_b), 0);
        chk("R4", "step count stays 1", int'(cnt_b), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_disabled;
        t_count;
        t_hit;
        t_priority;
        t_priv;
        t_step;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule